// File: doc/BRIEF.md
# ADC Acquisition Sequencer with Sample FIFO

This block is the control core of a 16-channel data-acquisition front end. A small register bus configures it: software picks a gain code, a channel (or the last channel of a scan) and the source that launches conversions. That source is a software write, a periodic pacer tick, or the rising edge of an external trigger. For each accepted trigger the block issues a one-cycle start to an external converter, along with the channel to sample. It waits for the converter's done pulse and then stores the returned 16-bit word in a sample queue. By default the queue holds 1024 words.

Software drains the queue by reading the data address. Each read returns the oldest word and removes it. A status address reports four flags: conversion in progress, queue full, queue at least half full, and data available. The full and half-full flags read low when their condition holds. With scanning enabled, successive conversions walk the channels from 0 up to the programmed last channel and then wrap back to 0. The multiplexer, amplifier, converter and bus bridge sit outside this block.

Top module: `acq_sequencer`

## Requirements
- R1: After reset the status address (2) reads 0x0060. This means bit 7 (busy) = 0, bit 6 (full, active low) = 1, bit 5 (half-full, active low) = 1, bit 4 (data available) = 0 and gain code [2:0] = 0. No start pulse is issued.
- R2: Writing address 2 stores data bits [2:0] as the gain code. The code drives `gainCode` and reads back in status bits [2:0].
- R3: Address 3 is the trigger mode. When it holds 0, any write to address 4 issues exactly one `convStart` pulse. With scanning off, `convChan` equals the channel last written to address 1.
- R4: In the mode register, bit 1 selects the pacer tick as the trigger source and bit 2 selects the external trigger's rising edge. Bit 2 wins over bit 1. Triggers from any source that is not selected are ignored.
- R5: When mode bit 0 is set, conversions sample channels 0, 1, …, L in turn and then wrap to 0, where L is the value in address 1. Any write to address 1 or address 3 restarts the walk at channel 0.
- R6: Status bit 7 is 1 from the cycle after a start until the converter's done pulse. Any trigger that arrives while bit 7 is 1 issues no start.
- R7: Each done pulse while busy pushes `convData` into the queue. A read of address 0 returns the oldest word and removes it. Status bit 4 is 1 exactly while the queue holds at least one word.
- R8: Status bit 5 reads 0 when the queue holds 512 or more words, and bit 6 reads 0 when it holds 1024. A word that arrives while the queue is full is discarded.
- R9: Any write to address 5 empties the queue in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdEn | input | 1 | Register read strobe (pops the queue at address 0) |
| regRdData | output | 16 | Register read data, combinational from address |
| pacerTick | input | 1 | Pacer tick, one trigger per high cycle |
| extTrig | input | 1 | External trigger, rising edge counts |
| convStart | output | 1 | One-cycle conversion start |
| convChan | output | 4 | Channel for the conversion being started |
| convDone | input | 1 | Converter done pulse |
| convData | input | 16 | Converted sample, valid with `convDone` |
| gainCode | output | 3 | Gain/range code to the amplifier |

## Verification
The converter stub tags each word with the channel it was started on and a running sequence number. This lets each read show both where a sample came from and whether any sample was lost or duplicated.

Triggering is tried in four ways:
- Single software writes, which confirm the one-start-per-write rule.
- A second write during busy, which separates accepting a trigger from dropping it.
- All three sources under each mode setting, which shows that selection masks the other sources and that the external trigger wins over the pacer.
- Scan runs longer than the scan length, which expose wrap-around errors.

The queue is filled to the exact counts 511, 512, 1023 and 1024 and then overfilled. Draining it afterwards shows that the overflow words were dropped and did not overwrite stored ones.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CHAN  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_MODE  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_SWTRG = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_FLUSH = 3'd5;

  typedef enum logic [1:0] {
    SRC_SOFT  = 2'd0,
    SRC_PACER = 2'd1,
    SRC_EXT   = 2'd2
  } trig_src_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifo_ctl_t;
endpackage

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int CHAN_W  = 4,
  parameter int RANGE_W = 3,
  parameter int BUS_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [BUS_W-1:0]   regWrData,
  input  logic               regRdEn,
  input  logic               pacerTick,
  input  logic               extTrig,
  input  logic               convDone,
  output fifo_ctl_t          fifoCtl,
  output logic               convStart,
  output logic [CHAN_W-1:0]  convChan,
  output logic [RANGE_W-1:0] gainCode,
  output logic               busy
);
  localparam int MODE_W = 3;

  logic [CHAN_W-1:0] chanReg;
  logic [CHAN_W-1:0] scanIdx;
  logic [MODE_W-1:0] modeReg;
  logic              extPrev;
  logic              wrChan, wrGain, wrMode, wrSoft, wrFlush;
  trig_src_e         trigSrc;
  logic              trigHit, startNow, doneNow;
  logic [CHAN_W-1:0] curChan;
  logic              unusedWrBits;

  assign unusedWrBits = ^regWrData;

  assign wrChan  = regWrEn && (regAddr == ADDR_CHAN);
  assign wrGain  = regWrEn && (regAddr == ADDR_STAT);
  assign wrMode  = regWrEn && (regAddr == ADDR_MODE);
  assign wrSoft  = regWrEn && (regAddr == ADDR_SWTRG);
  assign wrFlush = regWrEn && (regAddr == ADDR_FLUSH);

  always_comb begin
    if (modeReg[2])      trigSrc = SRC_EXT;
    else if (modeReg[1]) trigSrc = SRC_PACER;
    else                 trigSrc = SRC_SOFT;
  end

  always_comb begin
    unique case (trigSrc)
      SRC_PACER: trigHit = pacerTick;
      SRC_EXT:   trigHit = extTrig && !extPrev;
      default:   trigHit = wrSoft;
    endcase
  end

  assign startNow = trigHit && !busy;
  assign doneNow  = convDone && busy;
  assign curChan  = modeReg[0] ? scanIdx : chanReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chanReg   <= '0;
      gainCode  <= '0;
      modeReg   <= '0;
      extPrev   <= 1'b0;
      scanIdx   <= '0;
      busy      <= 1'b0;
      convStart <= 1'b0;
      convChan  <= '0;
    end else begin
      extPrev   <= extTrig;
      convStart <= startNow;
      if (wrChan) chanReg  <= regWrData[CHAN_W-1:0];
      if (wrGain) gainCode <= regWrData[RANGE_W-1:0];
      if (wrMode) modeReg  <= regWrData[MODE_W-1:0];
      if (startNow) begin
        busy     <= 1'b1;
        convChan <= curChan;
        if (modeReg[0]) scanIdx <= (scanIdx == chanReg) ? '0 : scanIdx + 1'b1;
      end else if (doneNow) begin
        busy <= 1'b0;
      end
      if (wrChan || wrMode) scanIdx <= '0;
    end
  end

  always_comb begin
    fifoCtl.push  = doneNow;
    fifoCtl.pop   = regRdEn && (regAddr == ADDR_DATA);
    fifoCtl.flush = wrFlush;
  end

  // R6: busy only ends with a done pulse
  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !convDone |=> busy);
  // R6: a start is never issued while a conversion is open
  assert_single_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    convStart |=> !convStart);
  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    convStart |-> busy);
  // R5: scan position stays within the programmed run
  assert_scan_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    scanIdx <= chanReg);
endmodule

// File: rtl/acq_fifo.sv
module acq_fifo
  import acq_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fifo_ctl_t         fifoCtl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] headData,
  output logic              full,
  output logic              halfFull,
  output logic              nonEmpty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W:0] DEPTH_C = (PTR_W+1)'(DEPTH);
  localparam logic [PTR_W:0] HALF_C  = (PTR_W+1)'(DEPTH / 2);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [PTR_W:0]    count;
  logic              doPush, doPop;

  assign full     = (count == DEPTH_C);
  assign halfFull = (count >= HALF_C);
  assign nonEmpty = (count != '0);
  assign doPush   = fifoCtl.push && !full;
  assign doPop    = fifoCtl.pop && nonEmpty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || fifoCtl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);
  assert_drop_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full && fifoCtl.push && !fifoCtl.pop && !fifoCtl.flush |=> full && $stable(wrPtr));
  assert_full_implies_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> halfFull);
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifoCtl.flush |=> !nonEmpty);
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_pkg::*;
#(
  parameter int NUM_CHAN = 16,
  parameter int DEPTH    = 1024,
  parameter int DATA_W   = 16,
  parameter int RANGE_W  = 3,
  parameter int BUS_W    = 8,
  localparam int CHAN_W  = $clog2(NUM_CHAN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [BUS_W-1:0]   regWrData,
  input  logic               regRdEn,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               pacerTick,
  input  logic               extTrig,
  output logic               convStart,
  output logic [CHAN_W-1:0]  convChan,
  input  logic               convDone,
  input  logic [DATA_W-1:0]  convData,
  output logic [RANGE_W-1:0] gainCode
);
  fifo_ctl_t         fifoCtl;
  logic              busy, full, halfFull, nonEmpty;
  logic [DATA_W-1:0] headData;

  acq_ctrl #(.CHAN_W(CHAN_W), .RANGE_W(RANGE_W), .BUS_W(BUS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .pacerTick(pacerTick),
    .extTrig(extTrig), .convDone(convDone), .fifoCtl(fifoCtl),
    .convStart(convStart), .convChan(convChan), .gainCode(gainCode), .busy(busy)
  );

  acq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .fifoCtl(fifoCtl), .wrData(convData),
    .headData(headData), .full(full), .halfFull(halfFull), .nonEmpty(nonEmpty)
  );

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_DATA) begin
      regRdData = headData;
    end else if (regAddr == ADDR_STAT) begin
      regRdData[7]           = busy;
      regRdData[6]           = !full;
      regRdData[5]           = !halfFull;
      regRdData[4]           = nonEmpty;
      regRdData[RANGE_W-1:0] = gainCode;
    end
  end
endmodule

// File: tb/acq_sequencer_bench.sv
module acq_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [15:0] regRdData;
  logic        pacerTick = 1'b0;
  logic        extTrig = 1'b0;
  logic        convStart;
  logic [3:0]  convChan;
  logic        convDone;
  logic [15:0] convData;
  logic [2:0]  gainCode;

  int checks = 0;
  int fails = 0;
  int startCount = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  acq_sequencer u_acq_sequencer (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .pacerTick(pacerTick), .extTrig(extTrig), .convStart(convStart),
    .convChan(convChan), .convDone(convDone), .convData(convData),
    .gainCode(gainCode)
  );

  // converter stub: done 4 cycles after start, word = {channel, sequence}
  logic [2:0]  stubCnt;
  logic        stubBusy;
  logic [3:0]  stubChan;
  logic [11:0] seqNum;
  always @(posedge clk) begin
    if (!rst_n) begin
      stubCnt <= '0; stubBusy <= 1'b0; stubChan <= '0; seqNum <= '0;
      convDone <= 1'b0; convData <= '0;
    end else begin
      convDone <= 1'b0;
      if (convStart) begin
        startCount <= startCount + 1;
        stubBusy <= 1'b1; stubCnt <= 3'd3; stubChan <= convChan;
      end else if (stubBusy) begin
        if (stubCnt == 0) begin
          convDone <= 1'b1;
          convData <= {stubChan, seqNum};
          seqNum   <= seqNum + 1'b1;
          stubBusy <= 1'b0;
        end else stubCnt <= stubCnt - 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = (a == 3'd0);
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic pulse_pacer();
    @(negedge clk); pacerTick = 1'b1;
    @(negedge clk); pacerTick = 1'b0;
  endtask

  task automatic pulse_ext();
    @(negedge clk); extTrig = 1'b1;
    @(negedge clk); extTrig = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] s;
    rd(3'd2, s);
    check(s == 16'h0060, "R1 status after reset", s, 16'h0060);
    check(startCount == 0, "R1 no start after reset", startCount, 0);
  endtask

  task automatic t_gain();
    logic [15:0] s;
    wr(3'd2, 8'hF5);
    rd(3'd2, s);
    check(s[2:0] == 3'd5, "R2 gain readback", s[2:0], 5);
    check(gainCode == 3'd5, "R2 gain pin", gainCode, 5);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_soft();
    logic [15:0] s, d;
    int st0;
    wr(3'd5, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h05);
    st0 = startCount;
    wr(3'd4, 8'hA5);
    settle();
    check(startCount == st0 + 1, "R3 one start per write", startCount - st0, 1);
    rd(3'd2, s);
    check(s[4] == 1'b1, "R7 data available bit", s[4], 1);
    rd(3'd0, d);
    check(d[15:12] == 4'd5, "R3 fixed channel", d[15:12], 5);
    rd(3'd2, s);
    check(s[4] == 1'b0, "R7 empty after pop", s[4], 0);
  endtask

  task automatic t_busy();
    logic [15:0] s;
    int st0;
    wr(3'd5, 8'h00);
    st0 = startCount;
    wr(3'd4, 8'h00);
    rd(3'd2, s);
    check(s[7] == 1'b1, "R6 busy during conversion", s[7], 1);
    wr(3'd4, 8'h00);
    settle();
    check(startCount == st0 + 1, "R6 trigger while busy ignored", startCount - st0, 1);
    rd(3'd2, s);
    check(s[7] == 1'b0, "R6 busy cleared after done", s[7], 0);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_modes();
    int st0;
    wr(3'd3, 8'h02);
    st0 = startCount;
    wr(3'd4, 8'h00); pulse_ext(); settle();
    check(startCount == st0, "R4 pacer mode ignores soft/ext", startCount - st0, 0);
    pulse_pacer(); settle();
    check(startCount == st0 + 1, "R4 pacer tick starts", startCount - st0, 1);
    wr(3'd3, 8'h06);
    st0 = startCount;
    pulse_pacer(); wr(3'd4, 8'h00); settle();
    check(startCount == st0, "R4 ext wins over pacer", startCount - st0, 0);
    pulse_ext(); settle();
    check(startCount == st0 + 1, "R4 ext edge starts", startCount - st0, 1);
    @(negedge clk); extTrig = 1'b1;
    repeat (12) @(negedge clk);
    extTrig = 1'b0;
    check(startCount == st0 + 2, "R4 held ext is one edge", startCount - st0, 2);
    wr(3'd3, 8'h00); wr(3'd5, 8'h00);
  endtask

  task automatic t_scan();
    logic [15:0] d;
    bit ok = 1;
    int badAct = 0, badExp = 0;
    wr(3'd5, 8'h00); wr(3'd1, 8'h02); wr(3'd3, 8'h01);
    for (int i = 0; i < 7; i++) begin wr(3'd4, 8'h00); settle(); end
    for (int i = 0; i < 7; i++) begin
      rd(3'd0, d);
      if (d[15:12] != 4'(i % 3) && ok) begin ok = 0; badAct = d[15:12]; badExp = i % 3; end
    end
    check(ok, "R5 scan order 0..2 wraps", badAct, badExp);
    wr(3'd4, 8'h00); settle();
    wr(3'd1, 8'h03);
    wr(3'd4, 8'h00); settle();
    rd(3'd0, d); rd(3'd0, d);
    check(d[15:12] == 4'd0, "R5 channel write restarts scan", d[15:12], 0);
    wr(3'd3, 8'h00); wr(3'd5, 8'h00);
  endtask

  task automatic t_fill();
    logic [15:0] s, d, first;
    int base, lastSeq;
    wr(3'd5, 8'h00); wr(3'd1, 8'h09); wr(3'd3, 8'h02);
    settle();
    base = seqNum;
    for (int i = 0; i < 511; i++) begin pulse_pacer(); repeat (6) @(negedge clk); end
    rd(3'd2, s);
    check(s[5] == 1'b1, "R8 half flag clear at 511", s[5], 1);
    pulse_pacer(); settle();
    rd(3'd2, s);
    check(s[5] == 1'b0, "R8 half flag low at 512", s[5], 0);
    for (int i = 0; i < 511; i++) begin pulse_pacer(); repeat (6) @(negedge clk); end
    settle();
    rd(3'd2, s);
    check(s[6] == 1'b1, "R8 full flag clear at 1023", s[6], 1);
    pulse_pacer(); settle();
    rd(3'd2, s);
    check(s[6] == 1'b0, "R8 full flag low at 1024", s[6], 0);
    pulse_pacer(); settle(); pulse_pacer(); settle();
    rd(3'd0, first);
    check(first[11:0] == 12'(base), "R7 oldest word first", first[11:0], base);
    rd(3'd2, s);
    check(s[6] == 1'b1, "R8 full clears after read", s[6], 1);
    lastSeq = 0;
    for (int i = 1; i < 1024; i++) begin rd(3'd0, d); lastSeq = d[11:0]; end
    check(lastSeq == ((base + 1023) % 4096), "R8 overflow words dropped", lastSeq, (base + 1023) % 4096);
    rd(3'd2, s);
    check(s[4] == 1'b0, "R8 empty after 1024 reads", s[4], 0);
    wr(3'd3, 8'h00);
  endtask

  task automatic t_flush();
    logic [15:0] s;
    for (int i = 0; i < 3; i++) begin wr(3'd4, 8'h00); settle(); end
    rd(3'd2, s);
    check(s[4] == 1'b1, "R9 data before flush", s[4], 1);
    wr(3'd5, 8'h77);
    rd(3'd2, s);
    check(s[4] == 1'b0 && s[5] == 1'b1, "R9 flush empties queue", s[5:4], 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gain();
    t_soft();
    t_busy();
    t_modes();
    t_scan();
    t_fill();
    t_flush();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R1-watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule